// File: doc/BRIEF.md
# Write-Only Codec Control Port Slave (Two-Wire Serial)

This block is the control-port slave of an audio codec. An external host writes it over a two-wire serial bus with clock SCL and open-drain data SDA. Both lines are brought into the system clock domain through a synchronizer and oversampled. Start and stop conditions and SCL edges are recovered from the sampled lines. A state machine then walks one transfer. It takes a device-address byte, and it acknowledges that byte only when the address matches and the transfer is a write. It then takes two data bytes. Together they form a 16-bit control word: bits [15:9] select a control register and bits [8:0] carry the new 9-bit value.

The block holds ten 9-bit control registers and drives them out in parallel. Register address 15 is a reset command: writing it returns every register to its default. The block never drives a read response or stretches the clock. Its only drive onto the bus is the acknowledge pull-down, given as `sda_oe_o`, which the pad uses to pull SDA low.

States of the transfer machine and their transitions:
- ST_IDLE: waits for a start condition (start → ST_ADDR).
- ST_ADDR: takes eight bits. On the falling SCL edge after the eighth bit it goes to ST_ADDR_ACK if the address matches and the direction bit is 0, and to ST_SKIP otherwise.
- ST_ADDR_ACK: drives the acknowledge (SCL fall → ST_HI).
- ST_HI: takes the upper data byte (eighth-bit fall → ST_HI_ACK).
- ST_HI_ACK: drives the acknowledge (SCL fall → ST_LO).
- ST_LO: takes the lower data byte (eighth-bit fall → ST_LO_ACK).
- ST_LO_ACK: drives the acknowledge. On the SCL fall that ends it, the word is committed and the machine goes to ST_SKIP.
- ST_SKIP: ignores the bus until the next start or stop.

From any state, a start goes to ST_ADDR and a stop goes to ST_IDLE.

Top module: `codec_ctl_i2c_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) begins a new address phase from any state. A stop condition (SDA rising while SCL is high) returns the block to idle.
- R2: The block answers device address 7'b0011010 when `cs_strap_i` is 0 and 7'b0011011 when it is 1. It does not acknowledge any other address, and no register changes in a transfer to another address.
- R3: An address byte whose direction bit (bit 0, sent last) is 1 gets no acknowledge and changes no register.
- R4: The block acknowledges the matching address byte and both data bytes by asserting `sda_oe_o` while SCL is high in the ninth clock of each byte. It never asserts `sda_oe_o` during the eight data bits.
- R5: Bytes are received MSB first. The first data byte is word bits [15:8] and the second is bits [7:0]. The register address is word[15:9] and the value is word[8:0].
- R6: A word with register address 0 to 9 loads its 9-bit value into register k. Register k appears at `regs_o[9k+8:9k]`.
- R7: A word with register address 15 loads every register with its default value. The default of register k is 16*k+3.
- R8: A word with register address 10 to 14 or 16 to 127 is acknowledged like any other and changes no register.
- R9: A start or stop condition that arrives before the second data byte's acknowledge has ended aborts the transfer and changes no register. A repeated start then begins a new transfer that completes normally.
- R10: Registers keep their old values until the falling SCL edge that ends the second data byte's acknowledge clock. They hold the new value once that edge has been recognized.
- R11: After reset, every register holds its default and `sda_oe_o` is low.
- R12: Bytes sent after the second data byte are not acknowledged and do not change the committed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample SCL and SDA |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_strap_i | input | 1 | Strap that selects the device address LSB |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | High to pull SDA low (acknowledge) |
| regs_o | output | 90 | Control registers; register k at bits [9k+8:9k] |

## Verification
All 128 device addresses are swept with the strap at 0, and a window around the match is swept with the strap at 1. Acknowledge versus silence separates the strap decode from a fixed address. Direction-bit-1 probes separate reads from writes. Every register address 0 to 15, plus 20 and 127, is written under both strap values with data computed from the address. This tells valid, unused and reset addresses apart and catches swapped bit fields, because the expected register image is tracked arithmetically. Aborts by stop after the first data byte, by a repeated start in the middle of the second byte, and by a start in the middle of the address byte show the commit point. Snapshots taken during the last acknowledge clock and a trailing third byte pin the commit point further.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int REG_W      = 9;
    localparam int RADDR_W    = 7;
    localparam int RESET_ADDR = 15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_HI,
        ST_HI_ACK,
        ST_LO,
        ST_LO_ACK,
        ST_SKIP
    } phase_t;

    // Power-on value of control register k
    function automatic logic [REG_W-1:0] reg_default(input int unsigned k);
        return REG_W'(16 * k + 3);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_d, sda_d;
    logic              scl_now, sda_now;

    assign scl_now = scl_sh[STAGES-1];
    assign sda_now = sda_sh[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_now;
            sda_d  <= sda_now;
        end
    end

    assign scl_rise_o = !scl_d && scl_now;
    assign scl_fall_o = scl_d && !scl_now;
    assign sda_o      = sda_now;
    assign start_o    = scl_d && scl_now && sda_d && !sda_now;
    assign stop_o     = scl_d && scl_now && !sda_d && sda_now;

endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
    import i2cw_pkg::*;
#(
    parameter logic [RADDR_W-1:0] BASE_ADDR = 7'b0011010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strap_i,
    input  logic               scl_rise_i,
    input  logic               scl_fall_i,
    input  logic               sda_i,
    input  logic               start_i,
    input  logic               stop_i,
    output logic               sda_oe_o,
    output logic               wr_en_o,
    output logic [RADDR_W-1:0] wr_addr_o,
    output logic [REG_W-1:0]   wr_data_o
);

    phase_t       state, state_nx;
    logic [3:0]   cnt;
    logic [7:0]   shreg, hi_q;
    logic         rx_phase, byte_done, addr_hit;
    logic [6:0]   my_addr;

    assign my_addr   = {BASE_ADDR[6:1], strap_i};
    assign rx_phase  = (state == ST_ADDR) || (state == ST_HI) || (state == ST_LO);
    assign byte_done = rx_phase && scl_fall_i && (cnt == 4'd8);
    assign addr_hit  = (shreg == {my_addr, 1'b0});

    always_comb begin
        state_nx = state;
        if (start_i) begin
            state_nx = ST_ADDR;
        end else if (stop_i) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (byte_done) state_nx = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall_i) state_nx = ST_HI;
                ST_HI:       if (byte_done) state_nx = ST_HI_ACK;
                ST_HI_ACK:   if (scl_fall_i) state_nx = ST_LO;
                ST_LO:       if (byte_done) state_nx = ST_LO_ACK;
                ST_LO_ACK:   if (scl_fall_i) state_nx = ST_SKIP;
                ST_SKIP:     state_nx = ST_SKIP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            shreg     <= '0;
            hi_q      <= '0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (start_i || stop_i || byte_done) begin
                cnt <= '0;
            end else if (rx_phase && scl_rise_i && (cnt != 4'd8)) begin
                shreg <= {shreg[6:0], sda_i};
                cnt   <= cnt + 4'd1;
            end
            if (state == ST_HI && byte_done) hi_q <= shreg;
            if (state == ST_LO_ACK && scl_fall_i && !start_i && !stop_i) begin
                wr_en_o   <= 1'b1;
                wr_addr_o <= hi_q[7:1];
                wr_data_o <= {hi_q[0], shreg};
            end
        end
    end

    always_comb begin
        sda_oe_o = (state == ST_ADDR_ACK) || (state == ST_HI_ACK) || (state == ST_LO_ACK);
    end

    p_start_enters_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state == ST_ADDR) && (cnt == 4'd0));

    p_stop_goes_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> (state == ST_IDLE) && !sda_oe_o);

    p_read_no_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && byte_done && shreg[0] && !start_i && !stop_i) |=> !sda_oe_o);

    p_commit_leaves_skip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (state == ST_SKIP || state == ST_ADDR || state == ST_IDLE) && !sda_oe_o);

    p_no_ack_during_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_phase && cnt != 4'd0) |-> !sda_oe_o);

endmodule

// File: rtl/ctrl_regfile.sv
module ctrl_regfile
    import i2cw_pkg::*;
#(
    parameter int NUM_REGS = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [RADDR_W-1:0]        wr_addr_i,
    input  logic [REG_W-1:0]          wr_data_i,
    output logic [NUM_REGS*REG_W-1:0] regs_o
);

    localparam logic [RADDR_W-1:0] RST_A = RADDR_W'(RESET_ADDR);

    function automatic logic [NUM_REGS*REG_W-1:0] all_defaults();
        logic [NUM_REGS*REG_W-1:0] v;
        for (int k = 0; k < NUM_REGS; k++) v[k*REG_W +: REG_W] = reg_default(k);
        return v;
    endfunction

    logic reset_cmd;
    assign reset_cmd = wr_en_i && (wr_addr_i == RST_A);

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        logic [REG_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                             q <= reg_default(k);
            else if (reset_cmd)                                     q <= reg_default(k);
            else if (wr_en_i && wr_addr_i == RADDR_W'(k))           q <= wr_data_i;
        end
        assign regs_o[k*REG_W +: REG_W] = q;

        p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wr_addr_i == RADDR_W'(k)) |=> regs_o[k*REG_W +: REG_W] == $past(wr_data_i));
    end

    p_reset_cmd_defaults_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_cmd |=> regs_o == all_defaults());

    p_unused_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i != RST_A && wr_addr_i >= RADDR_W'(NUM_REGS)) |=> $stable(regs_o));

    p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(regs_o));

endmodule

// File: rtl/codec_ctl_i2c_slave.sv
module codec_ctl_i2c_slave
    import i2cw_pkg::*;
#(
    parameter int                 SYNC_STAGES = 2,
    parameter logic [RADDR_W-1:0] BASE_ADDR   = 7'b0011010,
    parameter int                 NUM_REGS    = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_strap_i,
    input  logic                      scl_i,
    input  logic                      sda_i,
    output logic                      sda_oe_o,
    output logic [NUM_REGS*REG_W-1:0] regs_o
);

    logic scl_rise, scl_fall, sda_s, start_c, stop_c;
    logic wr_en;
    logic [RADDR_W-1:0] wr_addr;
    logic [REG_W-1:0]   wr_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .sda_o      (sda_s),
        .start_o    (start_c),
        .stop_o     (stop_c)
    );

    i2c_wr_fsm #(.BASE_ADDR(BASE_ADDR)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_i    (cs_strap_i),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .sda_i      (sda_s),
        .start_i    (start_c),
        .stop_i     (stop_c),
        .sda_oe_o   (sda_oe_o),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data)
    );

    ctrl_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .regs_o    (regs_o)
    );

endmodule

// File: tb/codec_ctl_i2c_slave_bench.sv
`timescale 1ns/1ps
module codec_ctl_i2c_slave_bench;

    localparam int NR = 10;
    localparam int W  = 9;
    localparam int Q  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic [NR*W-1:0] regs;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] expv [NR];

    always #2.5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    codec_ctl_i2c_slave u_codec_ctl_i2c_slave (
        .clk(clk), .rst_n(rst_n), .cs_strap_i(strap),
        .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe), .regs_o(regs)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what, input int act, input int expd);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expd);
        end
    endtask

    function automatic logic [NR*W-1:0] exp_flat();
        logic [NR*W-1:0] v;
        for (int k = 0; k < NR; k++) v[k*W +: W] = expv[k];
        return v;
    endfunction

    task automatic set_defaults();
        for (int k = 0; k < NR; k++) expv[k] = W'(16 * k + 3);
    endtask

    task automatic check_regs(input string req, input string what);
        for (int k = 0; k < NR; k++)
            check(regs[k*W +: W] == expv[k], req, what, int'(regs[k*W +: W]), int'(expv[k]));
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n, output bit spur);
        spur = 1'b0;
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(Q);
            scl = 1'b1;   tick(Q);
            if (sda_oe) spur = 1'b1;
            tick(Q);
            scl = 1'b0;   tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack, output bit spur,
                             output logic [NR*W-1:0] snap);
        send_bits(b, 8, spur);
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        ack  = sda_oe;
        snap = regs;
        tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic write_word(input logic [6:0] dev, input logic [6:0] ra, input logic [8:0] d,
                              input bit expect_ack, input string tag);
        bit a, s;
        logic [NR*W-1:0] sn;
        i2c_start();
        send_byte({dev, 1'b0}, a, s, sn);
        check(a == expect_ack, "R2", {tag, " address ack"}, a, expect_ack);
        check(!s, "R4", {tag, " no ack during address bits"}, s, 0);
        send_byte({ra, d[8]}, a, s, sn);
        check(a == expect_ack, "R4", {tag, " first data ack"}, a, expect_ack);
        send_byte(d[7:0], a, s, sn);
        check(a == expect_ack, "R4", {tag, " second data ack"}, a, expect_ack);
        check(sn == exp_flat(), "R10", {tag, " no update before last ack ends"}, 0, 0);
        i2c_stop();
        if (expect_ack) begin
            if (ra == 7'd15) set_defaults();
            else if (ra < 7'(NR)) expv[ra] = d;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit a, s;
        logic [NR*W-1:0] sn;
        logic [8:0] d;
        set_defaults();
        tick(5);
        rst_n = 1'b1;
        tick(5);
        check_regs("R11", "reset default");
        check(sda_oe == 1'b0, "R11", "sda released after reset", sda_oe, 0);

        // R2: full address sweep with strap 0
        for (int ad = 0; ad < 128; ad++) begin
            i2c_start();
            send_byte({7'(ad), 1'b0}, a, s, sn);
            check(a == (ad == 7'h1A), "R2", "strap0 address sweep", a, ad == 7'h1A);
            i2c_stop();
        end
        // R2: window around the match with strap 1
        strap = 1'b1;
        for (int ad = 8'h18; ad < 8'h20; ad++) begin
            i2c_start();
            send_byte({7'(ad), 1'b0}, a, s, sn);
            check(a == (ad == 7'h1B), "R2", "strap1 address sweep", a, ad == 7'h1B);
            i2c_stop();
        end

        // R3: read direction is not acknowledged
        for (int st = 0; st < 2; st++) begin
            strap = st[0];
            i2c_start();
            send_byte({7'h1A | 7'(st), 1'b1}, a, s, sn);
            check(!a, "R3", "read request no ack", a, 0);
            send_byte(8'h55, a, s, sn);
            check(!a, "R3", "byte after read no ack", a, 0);
            i2c_stop();
            check_regs("R3", "read changes nothing");
        end

        // R5 R6 R7 R8: register address sweep under both straps
        for (int st = 0; st < 2; st++) begin
            strap = st[0];
            for (int ra = 0; ra < 16; ra++) begin
                d = 9'((ra * 37 + st * 101 + 11) & 511);
                write_word(7'h1A | 7'(st), 7'(ra), d, 1'b1, "sweep");
                if (ra == 15)      check_regs("R7", "reset register restores defaults");
                else if (ra >= NR) check_regs("R8", "unused address discarded");
                else               check_regs("R6", "register written with R5 split");
            end
            write_word(7'h1A | 7'(st), 7'd20, 9'h1FF, 1'b1, "unused20");
            check_regs("R8", "address 20 discarded");
            write_word(7'h1A | 7'(st), 7'd127, 9'h0AA, 1'b1, "unused127");
            check_regs("R8", "address 127 discarded");
        end

        // R6: fill all registers, then R7 reset again
        strap = 1'b0;
        for (int ra = 0; ra < NR; ra++) write_word(7'h1A, 7'(ra), 9'(9'h100 | ra), 1'b1, "fill");
        check_regs("R6", "all registers filled");
        write_word(7'h1A, 7'd15, 9'h000, 1'b1, "reset");
        check_regs("R7", "defaults after fill");

        // R2: wrong device address full transfer
        write_word(7'h1C, 7'd2, 9'h0F0, 1'b0, "wrongdev");
        check_regs("R2", "other device changes nothing");

        // R12: trailing byte not acknowledged
        i2c_start();
        send_byte({7'h1A, 1'b0}, a, s, sn);
        send_byte({7'd3, 1'b1}, a, s, sn);
        send_byte(8'h2D, a, s, sn);
        send_byte(8'hFF, a, s, sn);
        check(!a, "R12", "third data byte no ack", a, 0);
        i2c_stop();
        expv[3] = 9'h12D;
        check_regs("R12", "committed value kept");

        // R9: stop after first data byte aborts
        i2c_start();
        send_byte({7'h1A, 1'b0}, a, s, sn);
        send_byte({7'd4, 1'b0}, a, s, sn);
        i2c_stop();
        check_regs("R9", "stop after first byte aborts");

        // R9: repeated start mid second byte, then full transfer
        i2c_start();
        send_byte({7'h1A, 1'b0}, a, s, sn);
        send_byte({7'd5, 1'b1}, a, s, sn);
        send_bits(8'h3C, 4, s);
        i2c_start();
        check_regs("R9", "repeated start aborts");
        send_byte({7'h1A, 1'b0}, a, s, sn);
        check(a, "R9", "address ack after repeated start", a, 1);
        send_byte({7'd6, 1'b0}, a, s, sn);
        send_byte(8'h77, a, s, sn);
        i2c_stop();
        expv[6] = 9'h077;
        check_regs("R9", "transfer after repeated start lands");

        // R1: start in middle of address byte restarts address phase
        i2c_start();
        send_bits(8'h34, 3, s);
        i2c_start();
        send_byte({7'h1A, 1'b0}, a, s, sn);
        check(a, "R1", "start restarts address phase", a, 1);
        send_byte({7'd7, 1'b0}, a, s, sn);
        send_byte(8'h5A, a, s, sn);
        i2c_stop();
        expv[7] = 9'h05A;
        check_regs("R1", "write after restart");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule